// File: doc/BRIEF.md
# Programmable Interval Down-Counter

This block is a down-counting timer that sits behind a small word-indexed register port. Software programs a limit, picks a counting mode, a counter width and a clock prescale, then enables it. On each prescaled clock enable the counter steps down by one. When it reaches zero it raises a sticky interrupt flag. On the next enable it either reloads or stays at zero, depending on the mode.

Free-running mode reloads the full-scale value of the selected width. Periodic mode reloads the programmed limit. One-shot mode parks at zero. Two registers set the limit. One of them also forces the counter to the new value at once. The other only takes effect at the next reload. The interrupt output is the sticky flag gated by an enable bit in the control register. A write to a dedicated index clears the flag.

Top module: `interval_timer`

## Requirements
- R1: Registers are chosen by a 3-bit word index: 0 = limit with immediate load, 1 = current value (writes ignored), 2 = control (8 bits, all read back), 3 = flag clear (reads 0), 4 = raw flag in bit 0, 5 = gated flag in bit 0, 6 = limit without load. Index 7 reads 0 and ignores writes. Indices 0 and 6 both read the limit.
- R2: After synchronous active-low reset: control reads 0x20, limit reads 0, the current value reads 0x0000FFFF (all ones, seen through the 16-bit view), the raw flag is 0 and irq_out is 0.
- R3: Control bit 7 enables counting. While it is 0, the counter holds its value.
- R4: Control bits [3:2] set the prescale: 00 or 11 gives an enable on every enabled clock, 01 gives one in every 16, 10 gives one in every 256. The prescale phase restarts from zero on every write to index 0 or index 2, so the first enable comes 1, 16 or 256 enabled clocks after that write.
- R5: On a prescaled enable, a nonzero counter decrements. The step from 1 to 0 is the expiry, and it sets the raw flag at that same edge.
- R6: With control bit 6 clear (free-running), an enable at zero reloads 0xFFFFFFFF when bit 1 is set (32-bit) and 0x0000FFFF when it is clear (16-bit).
- R7: With control bit 6 set (periodic), an enable at zero reloads the current limit.
- R8: With control bit 0 set (one-shot), an enable at zero leaves the counter at zero and does not reload.
- R9: A write to index 0 sets the limit and the counter in that cycle, taking precedence over any enable. A write to index 6 changes only the limit.
- R10: With control bit 1 clear, only bits [15:0] count, and the value reads with bits [31:16] as zero.
- R11: irq_out is 1 exactly when the raw flag is 1 and control bit 5 is set. Index 5 reads the same gated flag.
- R12: Any write to index 3 clears the raw flag, except when an expiry happens in the same cycle; then the flag is set.
- R13: A write to index 2 suppresses the enable in that cycle. Counting then resumes from the held value if bit 7 of the new control is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Level interrupt: raw flag gated by the enable bit |

## Verification
The assertions check these behaviours on every cycle:
- the counter holds while disabled (R3);
- a one-shot stays parked at zero (R8);
- an expiry sets the flag (R5);
- a clear with no expiry drops the flag (R12);
- an immediate load lands in the counter (R9);
- no enable happens in a control-write cycle (R13);
- an unmasked expiry raises the interrupt (R11).

Only the bench's scenarios can show the following:
- the reload values of each mode and width (R6, R7, R10);
- the exact spacing of prescaled enables (R4);
- that a deferred limit waits for the next reload (R9).

The bench shows these by comparing every read and the interrupt against its reference model, clock by clock.

// File: rtl/itimer_pkg.sv
// Shared definitions for the interval timer: register indices, control
// bit positions and prescale codes. Assumes a 3-bit word index.
package itimer_pkg;

    localparam int IDX_W = 3;
    localparam int CTRL_W = 8;

    typedef enum logic [IDX_W-1:0] {
        IDX_LOAD   = 3'd0,
        IDX_VALUE  = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_ICLR   = 3'd3,
        IDX_RAW    = 3'd4,
        IDX_MASKED = 3'd5,
        IDX_DEFER  = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_e;

    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PS_LO    = 2;
    localparam int CB_PS_HI    = 3;
    localparam int CB_IE       = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_RUN      = 7;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_RSVD   = 2'd3
    } prescale_e;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/itimer_prescale.sv
// Prescaler: produces the counting enable. A phase counter advances on
// every clock while running and is cleared by a restart request. Assumes
// LOG_B >= LOG_A and PRE_W >= LOG_B.
module itimer_prescale #(
    parameter int PRE_W = 8,
    parameter int LOG_A = 4,
    parameter int LOG_B = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    import itimer_pkg::*;

    logic [PRE_W-1:0] phase_q;
    logic             terminal;

    // Phase counter: cleared on restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= phase_q + 1'b1;
    end

    // Terminal phase detection for the selected division.
    always_comb begin
        unique case (prescale_e'(sel))
            PS_DIV16:  terminal = &phase_q[LOG_A-1:0];
            PS_DIV256: terminal = &phase_q[LOG_B-1:0];
            default:   terminal = 1'b1;
        endcase
    end

    // Enable is withheld in any restart cycle.
    assign tick = run && !restart && terminal;

endmodule

// File: rtl/itimer_counter.sv
// Down-counter core. Presents a W-bit or NW-bit view selected by 'wide'.
// Decrements on tick and reloads on a tick at zero unless one-shot.
// A load has priority over a tick. Flags expiry on the 1 -> 0 step.
module itimer_counter #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         oneshot,
    input  logic         wide,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam int PAD_W = W - NW;

    logic [W-1:0] cnt_q;
    logic [W-1:0] view;
    logic         at_zero;
    logic         at_one;

    // Width view of the stored count.
    always_comb begin
        view    = wide ? cnt_q : {{PAD_W{1'b0}}, cnt_q[NW-1:0]};
        at_zero = (view == '0);
        at_one  = (view == W'(1));
    end

    // Count register: load, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (!at_zero)      cnt_q <= view - 1'b1;
            else if (!oneshot) cnt_q <= reload_val;
        end
    end

    assign count  = view;
    assign expire = tick && !load_en && at_one;

endmodule

// File: rtl/itimer_regs.sv
// Register file: write decode, control and limit storage, sticky flag,
// read multiplexer and interrupt gating. Assumes a single-cycle port
// with combinational read.
module itimer_regs #(
    parameter int W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [itimer_pkg::IDX_W-1:0]   addr,
    input  logic [W-1:0]                   wdata,
    input  logic [W-1:0]                   count,
    input  logic                           expire,
    output logic [itimer_pkg::CTRL_W-1:0]  ctrl_q,
    output logic [W-1:0]                   limit_q,
    output logic                           raw_q,
    output logic                           load_wr,
    output logic                           ctrl_wr,
    output logic [W-1:0]                   rdata,
    output logic                           irq
);
    import itimer_pkg::*;

    logic clr_wr;
    logic defer_wr;

    // Write strobes per index.
    always_comb begin
        load_wr  = wr && (addr == IDX_LOAD);
        ctrl_wr  = wr && (addr == IDX_CTRL);
        clr_wr   = wr && (addr == IDX_ICLR);
        defer_wr = wr && (addr == IDX_DEFER);
    end

    // Control and limit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            limit_q <= '0;
        end else begin
            if (ctrl_wr)             ctrl_q  <= wdata[CTRL_W-1:0];
            if (load_wr || defer_wr) limit_q <= wdata;
        end
    end

    // Sticky flag: an expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (expire) raw_q <= 1'b1;
        else if (clr_wr) raw_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        unique case (reg_idx_e'(addr))
            IDX_LOAD, IDX_DEFER: rdata = limit_q;
            IDX_VALUE:           rdata = count;
            IDX_CTRL:            rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            IDX_RAW:             rdata = {{(W-1){1'b0}}, raw_q};
            IDX_MASKED:          rdata = {{(W-1){1'b0}}, irq};
            default:             rdata = '0;
        endcase
    end

    assign irq = raw_q && ctrl_q[CB_IE];

endmodule

// File: rtl/interval_timer.sv
// Top of the interval timer: ties the register file, the prescaler and
// the counter core together and selects the reload value by mode.
module interval_timer #(
    parameter int W     = 32,
    parameter int NW    = 16,
    parameter int PRE_W = 8,
    parameter int LOG_A = 4,
    parameter int LOG_B = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [itimer_pkg::IDX_W-1:0] reg_addr,
    input  logic [W-1:0]                 reg_wdata,
    output logic [W-1:0]                 reg_rdata,
    output logic                         irq_out
);
    import itimer_pkg::*;

    localparam logic [W-1:0] FULL_WIDE   = '1;
    localparam logic [W-1:0] FULL_NARROW = {{(W-NW){1'b0}}, {NW{1'b1}}};

    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      limit_q;
    logic [W-1:0]      count_q;
    logic [W-1:0]      reload_val;
    logic              raw_q;
    logic              load_wr;
    logic              ctrl_wr;
    logic              tick;
    logic              expire;

    itimer_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .count   (count_q),
        .expire  (expire),
        .ctrl_q  (ctrl_q),
        .limit_q (limit_q),
        .raw_q   (raw_q),
        .load_wr (load_wr),
        .ctrl_wr (ctrl_wr),
        .rdata   (reg_rdata),
        .irq     (irq_out)
    );

    itimer_prescale #(.PRE_W(PRE_W), .LOG_A(LOG_A), .LOG_B(LOG_B)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[CB_RUN]),
        .restart (load_wr || ctrl_wr),
        .sel     (ctrl_q[CB_PS_HI:CB_PS_LO]),
        .tick    (tick)
    );

    // Reload value by mode and width.
    always_comb begin
        if (ctrl_q[CB_PERIODIC]) reload_val = limit_q;
        else if (ctrl_q[CB_WIDE]) reload_val = FULL_WIDE;
        else                      reload_val = FULL_NARROW;
    end

    itimer_counter #(.W(W), .NW(NW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (load_wr),
        .load_val   (reg_wdata),
        .reload_val (reload_val),
        .oneshot    (ctrl_q[CB_ONESHOT]),
        .wide       (ctrl_q[CB_WIDE]),
        .count      (count_q),
        .expire     (expire)
    );

endmodule

// File: rtl/itimer_chk.sv
// Checker for the interval timer, bound to every instance of the top.
// Observes the bus inputs and internal state driven by separate submodules.
module itimer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [2:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [7:0]   ctrl_q,
    input logic [W-1:0] count_q,
    input logic         raw_q,
    input logic         tick,
    input logic         expire,
    input logic         irq_out
);
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && !(reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd2)))
        |=> $stable(count_q));

    // R8
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && ctrl_q[0] && count_q == '0 && !reg_wr) |=> (count_q == '0));

    // R5
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q);

    // R12
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && !expire) |=> !raw_q);

    // R9
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && ctrl_q[1]) |=> (count_q == $past(reg_wdata)));

    // R13
    ctrl_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |-> !tick);

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q[5] && !(reg_wr && reg_addr == 3'd2)) |=> irq_out);

endmodule

bind interval_timer itimer_chk #(.W(W)) u_itimer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl_q    (ctrl_q),
    .count_q   (count_q),
    .raw_q     (raw_q),
    .tick      (tick),
    .expire    (expire),
    .irq_out   (irq_out)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared after every clock edge,
// plus directed scenarios with hand-computed values.
module test_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    interval_timer i_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    // Reference model state.
    int unsigned m_cnt, m_limit, m_eff, m_div;
    bit [7:0]    m_ctrl;
    int          m_pre;
    bit          m_raw, m_tk, m_exp, m_ldw, m_ctw;

    function automatic int unsigned view(int unsigned c, bit [7:0] ct);
        return ct[1] ? c : (c & 32'h0000FFFF);
    endfunction

    function automatic int unsigned model_rd(logic [2:0] a);
        case (a)
            3'd0, 3'd6: return m_limit;
            3'd1:       return view(m_cnt, m_ctrl);
            3'd2:       return {24'd0, m_ctrl};
            3'd4:       return {31'd0, m_raw};
            3'd5:       return {31'd0, m_raw && m_ctrl[5]};
            default:    return 0;
        endcase
    endfunction

    // Model update at each edge, from the inputs held across that edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 32'hFFFFFFFF; m_limit = 0; m_ctrl = 8'h20; m_pre = 0; m_raw = 0;
        end else begin
            m_ldw = reg_wr && reg_addr == 3'd0;
            m_ctw = reg_wr && reg_addr == 3'd2;
            m_div = (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
            m_tk  = m_ctrl[7] && !m_ldw && !m_ctw && ((m_pre % m_div) == m_div - 1);
            m_eff = view(m_cnt, m_ctrl);
            m_exp = m_tk && m_eff == 1;
            if (m_ldw) m_cnt = reg_wdata;
            else if (m_tk) begin
                if (m_eff != 0) m_cnt = m_eff - 1;
                else if (!m_ctrl[0]) m_cnt = m_ctrl[6] ? m_limit : (m_ctrl[1] ? 32'hFFFFFFFF : 32'h0000FFFF);
            end
            if (m_exp) m_raw = 1;
            else if (reg_wr && reg_addr == 3'd3) m_raw = 0;
            if (m_ldw || m_ctw) m_pre = 0;
            else if (m_ctrl[7]) m_pre = (m_pre + 1) % 256;
            if (m_ldw || (reg_wr && reg_addr == 3'd6)) m_limit = reg_wdata;
            if (m_ctw) m_ctrl = reg_wdata[7:0];
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Compare the outputs against the model (off the clock edge).
    task automatic cmp_model();
        check(reg_addr == 3'd1 ? "R5" : "R1", "model read", reg_rdata, model_rd(reg_addr));
        check("R11", "model irq", {31'd0, irq_out}, {31'd0, m_raw && m_ctrl[5]});
    endtask

    task automatic step();
        @(posedge clk); #1;
        cmp_model();
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic peek(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a; #1;
        check(req, "directed read", reg_rdata, exp);
        check(req, "model read", reg_rdata, model_rd(a));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2 reset state
        peek("R2", 3'd2, 32'h20);
        peek("R2", 3'd1, 32'h0000FFFF);
        peek("R2", 3'd0, 32'h0);
        peek("R2", 3'd4, 32'h0);
        check("R2", "irq after reset", {31'd0, irq_out}, 32'd0);

        // R7 periodic, R13 pause on control write, R5 expiry
        wr_reg(3'd0, 32'd3);
        wr_reg(3'd2, 32'hE2);
        peek("R13", 3'd1, 32'd3);
        idle(3);
        peek("R5", 3'd1, 32'd0);
        check("R11", "irq on expiry", {31'd0, irq_out}, 32'd1);
        idle(1);
        peek("R7", 3'd1, 32'd3);

        // R12 clear with no expiry
        wr_reg(3'd3, 32'd0);
        check("R12", "irq after clear", {31'd0, irq_out}, 32'd0);

        // R8 one-shot
        wr_reg(3'd0, 32'd2);
        wr_reg(3'd2, 32'hA3);
        idle(3);
        peek("R8", 3'd1, 32'd0);

        // R6 and R10 free-running 16-bit
        wr_reg(3'd0, 32'd1);
        wr_reg(3'd2, 32'hA0);
        idle(2);
        peek("R10", 3'd1, 32'h0000FFFF);

        // R6 free-running 32-bit
        wr_reg(3'd0, 32'd1);
        wr_reg(3'd2, 32'h82);
        idle(2);
        peek("R6", 3'd1, 32'hFFFFFFFF);

        // R4 divide by 16
        wr_reg(3'd0, 32'd100);
        wr_reg(3'd2, 32'h86);
        idle(15);
        peek("R4", 3'd1, 32'd100);
        idle(1);
        peek("R4", 3'd1, 32'd99);

        // R3 disabled holds
        wr_reg(3'd2, 32'h06);
        idle(300);
        peek("R3", 3'd1, 32'd99);

        // R9 deferred limit, R1 readback
        wr_reg(3'd6, 32'd7);
        peek("R9", 3'd1, 32'd99);
        peek("R9", 3'd6, 32'd7);
        peek("R1", 3'd0, 32'd7);
        peek("R1", 3'd2, 32'h06);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        peek("R1", 3'd7, 32'd0);
        wr_reg(3'd1, 32'd5);
        peek("R1", 3'd1, 32'd99);

        // R12 set wins over clear; R11 gating with IE off
        wr_reg(3'd0, 32'd1);
        wr_reg(3'd2, 32'hC2);
        wr_reg(3'd3, 32'd0);
        peek("R12", 3'd4, 32'd1);
        peek("R11", 3'd5, 32'd0);
        check("R11", "irq masked", {31'd0, irq_out}, 32'd0);

        // Mixed traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                logic [2:0]  a;
                logic [31:0] d;
                a = 3'($urandom_range(0, 7));
                d = (a == 3'd2) ? (32'($urandom) & 32'hFFF3) | (32'($urandom_range(0, 1)) << 2)
                                : 32'($urandom_range(0, 40));
                wr_reg(a, d);
            end else begin
                reg_addr = 3'($urandom_range(0, 7));
                step();
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule